// File: doc/BRIEF.md
# Bus Transaction Phase Tracker

This block watches a synchronous, multiplexed address/data bus whose handshakes are all active low: a frame strobe, initiator and target ready strobes, a target-select strobe and a target stop strobe. It never drives the bus. It reports what the bus is doing as registered flags and pulses: the address clock, each completed data transfer, each wait clock, the final data phase, whether a target has claimed the cycle, and whether the target is asking the initiator to stop. The command and address seen in the address clock are latched and held for the rest of the transaction.

Every input is captured on the rising clock edge into a sampling register. A phase state machine (idle, data, turnaround) then decodes those samples, and all results are registered again. Each output therefore describes the bus clock that was sampled two rising edges earlier. A saturating counter reports how many consecutive wait clocks the current data phase has accumulated.

The grant input and the request output are handled only as far as reset needs. While reset is held, the grant is ignored and the request output enable is forced off. Outside reset, the grant and a local request are passed through the same two-stage path.

Top module: `busphase_tracker`

## Requirements
- R1: When the bus is idle, or the tracker is in the turnaround clock after a final completion with the initiator ready strobe high, a sampled low frame strobe is an address clock. `addr_phase` pulses for that clock only, and `addr`/`cmd` load the raw AD and C/BE# values of that clock and hold them until the next address clock.
- R2: `xfer` pulses for each data-phase clock in which the initiator and target ready strobes are both low.
- R3: `wait_st` is high for each data-phase clock that neither ends the phase nor abandons the transaction, and it is never high together with `xfer`.
- R4: `wait_cnt` counts the consecutive wait clocks of the current data phase and holds at 2^WAIT_W-1 instead of wrapping. It returns to 0 when a phase ends, at an address clock and on abandonment.
- R5: `last_phase` is high for each data-phase clock in which the frame strobe is high and the initiator ready strobe is low.
- R6: `stop_req` is high for each data-phase clock with the stop strobe low. Initiator ready together with stop, without target ready, ends the data phase with no `xfer`.
- R7: `claimed` goes high once the target-select strobe is sampled low during a transaction. It stays high until the bus returns to idle or a new address clock occurs.
- R8: `busy` is high from the address clock onward. It falls when frame and initiator ready are both sampled high, either in the turnaround clock or inside a data phase (abandonment). While `busy` is low, every phase flag is low.
- R9: Reset is synchronous and active high. While it is held, all flags are 0, `req_oe` is 0, `req_n` is 1 and `gnt_ok` is 0, whatever the grant input does. A reset in mid-transaction returns the tracker to idle.
- R10: Out of reset, `req_oe` is 1 from the first edge. `gnt_ok` equals the inverse of `gnt_n`, and `req_n` equals the inverse of `req_want`, two edges after the input is presented.
- R11: Every phase flag reflects the bus values presented before the rising edge two edges earlier (one sampling stage and one output stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Target select, active low |
| stop_n | input | 1 | Target stop request, active low |
| ad | input | AD_W | Multiplexed address/data |
| cbe_n | input | CBE_W | Command / byte enables |
| gnt_n | input | 1 | Bus grant, active low |
| req_want | input | 1 | Local wish to request the bus |
| addr_phase | output | 1 | Address clock pulse |
| xfer | output | 1 | Data transfer pulse |
| wait_st | output | 1 | Wait clock flag |
| last_phase | output | 1 | Final data phase flag |
| stop_req | output | 1 | Target stop request flag |
| claimed | output | 1 | A target has claimed the transaction |
| busy | output | 1 | Transaction in progress |
| wait_cnt | output | WAIT_W | Saturating wait clock count |
| addr | output | AD_W | Latched address |
| cmd | output | CBE_W | Latched command |
| gnt_ok | output | 1 | Grant seen, gated by reset |
| req_n | output | 1 | Request, active low |
| req_oe | output | 1 | Request output enable |

## Verification
The checker covers the rules that must hold in every clock. These are: the address pulse is a single clock and implies `busy`, a transfer never coincides with a wait, the wait count is non-zero during a wait and cleared at a transfer and never wraps, `last_phase` and `claimed` occur only while `busy`, an idle bus shows no phase flags, and reset forces the request enable off and the grant flag low. Only the bench scenarios can show the exact sequence of flags for a normal burst, a stop-terminated transaction, an abandoned one and a back-to-back one. The bench alone also shows the latched address and command values, the two-edge latency and the count reaching its ceiling after a long stall.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TURN = 2'd2
  } bpt_state_e;

  // handshakes after sampling, converted to asserted-high
  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic devsel;
    logic stop;
  } bpt_hs_t;

endpackage

// File: rtl/bpt_sampler.sv
module bpt_sampler
  import bpt_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n,
  input  logic             gnt_n,
  input  logic             req_want,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe_n,
  output bpt_hs_t          hs,
  output logic             gnt_s,
  output logic             want_s,
  output logic [AD_W-1:0]  ad_s,
  output logic [CBE_W-1:0] cbe_s
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs     <= '0;
      gnt_s  <= 1'b0;
      want_s <= 1'b0;
      ad_s   <= '0;
      cbe_s  <= '0;
    end else begin
      hs.frame  <= ~frame_n;
      hs.irdy   <= ~irdy_n;
      hs.trdy   <= ~trdy_n;
      hs.devsel <= ~devsel_n;
      hs.stop   <= ~stop_n;
      gnt_s     <= ~gnt_n;
      want_s    <= req_want;
      ad_s      <= ad;
      cbe_s     <= cbe_n;
    end
  end

endmodule

// File: rtl/bpt_phase_fsm.sv
module bpt_phase_fsm
  import bpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bpt_hs_t    hs,
  output bpt_state_e state_nx,
  output logic       addr_hit,
  output logic       phase_end,
  output logic       xfer_now,
  output logic       wait_now,
  output logic       final_now,
  output logic       stop_now,
  output logic       abandon
);

  bpt_state_e state;
  logic       in_data;

  always_comb begin
    in_data   = (state == ST_DATA);
    addr_hit  = hs.frame && ((state == ST_IDLE) || ((state == ST_TURN) && !hs.irdy));
    abandon   = in_data && !hs.frame && !hs.irdy;
    phase_end = in_data && hs.irdy && (hs.trdy || hs.stop);
    xfer_now  = in_data && hs.irdy && hs.trdy;
    final_now = in_data && !hs.frame && hs.irdy;
    wait_now  = in_data && !phase_end && !abandon;
    stop_now  = in_data && hs.stop && !abandon;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (addr_hit) state_nx = ST_DATA;
      ST_DATA: begin
        if (abandon)                     state_nx = ST_IDLE;
        else if (phase_end && !hs.frame) state_nx = ST_TURN;
      end
      ST_TURN: begin
        if (addr_hit)                    state_nx = ST_DATA;
        else if (!hs.frame && !hs.irdy)  state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

endmodule

// File: rtl/bpt_wait_ctr.sv
module bpt_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CEIL = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (inc && cnt != CEIL) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/busphase_tracker.sv
module busphase_tracker
  import bpt_pkg::*;
#(
  parameter int AD_W   = 32,
  parameter int CBE_W  = 4,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              devsel_n,
  input  logic              stop_n,
  input  logic [AD_W-1:0]   ad,
  input  logic [CBE_W-1:0]  cbe_n,
  input  logic              gnt_n,
  input  logic              req_want,
  output logic              addr_phase,
  output logic              xfer,
  output logic              wait_st,
  output logic              last_phase,
  output logic              stop_req,
  output logic              claimed,
  output logic              busy,
  output logic [WAIT_W-1:0] wait_cnt,
  output logic [AD_W-1:0]   addr,
  output logic [CBE_W-1:0]  cmd,
  output logic              gnt_ok,
  output logic              req_n,
  output logic              req_oe
);

  bpt_hs_t          hs;
  logic             gnt_s, want_s;
  logic [AD_W-1:0]  ad_s;
  logic [CBE_W-1:0] cbe_s;
  bpt_state_e       state_nx;
  logic             addr_hit, phase_end, xfer_now, wait_now;
  logic             final_now, stop_now, abandon;
  logic             claimed_d;

  bpt_sampler #(.AD_W(AD_W), .CBE_W(CBE_W)) u_smp (
    .clk(clk), .rst(rst),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .stop_n(stop_n),
    .gnt_n(gnt_n), .req_want(req_want),
    .ad(ad), .cbe_n(cbe_n),
    .hs(hs), .gnt_s(gnt_s), .want_s(want_s), .ad_s(ad_s), .cbe_s(cbe_s)
  );

  bpt_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .hs(hs),
    .state_nx(state_nx), .addr_hit(addr_hit), .phase_end(phase_end),
    .xfer_now(xfer_now), .wait_now(wait_now), .final_now(final_now),
    .stop_now(stop_now), .abandon(abandon)
  );

  bpt_wait_ctr #(.W(WAIT_W)) u_wctr (
    .clk(clk), .rst(rst),
    .clr(addr_hit || phase_end || abandon),
    .inc(wait_now),
    .cnt(wait_cnt)
  );

  // claim is sticky inside a transaction
  always_comb begin
    if (state_nx == ST_IDLE) claimed_d = 1'b0;
    else if (addr_hit)       claimed_d = 1'b0;
    else if (hs.devsel)      claimed_d = 1'b1;
    else                     claimed_d = claimed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_phase <= 1'b0;
      xfer       <= 1'b0;
      wait_st    <= 1'b0;
      last_phase <= 1'b0;
      stop_req   <= 1'b0;
      claimed    <= 1'b0;
      busy       <= 1'b0;
      addr       <= '0;
      cmd        <= '0;
      gnt_ok     <= 1'b0;
      req_n      <= 1'b1;
      req_oe     <= 1'b0;
    end else begin
      addr_phase <= addr_hit;
      xfer       <= xfer_now;
      wait_st    <= wait_now;
      last_phase <= final_now;
      stop_req   <= stop_now;
      claimed    <= claimed_d;
      busy       <= (state_nx != ST_IDLE);
      if (addr_hit) begin
        addr <= ad_s;
        cmd  <= cbe_s;
      end
      gnt_ok     <= gnt_s;
      req_n      <= ~want_s;
      req_oe     <= 1'b1;
    end
  end

endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_phase,
  input logic              xfer,
  input logic              wait_st,
  input logic              last_phase,
  input logic              stop_req,
  input logic              claimed,
  input logic              busy,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic              gnt_ok,
  input logic              req_n,
  input logic              req_oe
);

  localparam logic [WAIT_W-1:0] CEIL = '1;

  p_addr_single_r1: assert property (@(posedge clk) disable iff (rst)
    addr_phase |=> !addr_phase);

  p_addr_busy_r1: assert property (@(posedge clk) disable iff (rst)
    addr_phase |-> busy);

  p_xfer_not_wait_r3: assert property (@(posedge clk) disable iff (rst)
    !(xfer && wait_st));

  p_wait_counted_r4: assert property (@(posedge clk) disable iff (rst)
    wait_st |-> (wait_cnt != '0));

  p_clear_on_xfer_r4: assert property (@(posedge clk) disable iff (rst)
    xfer |-> (wait_cnt == '0));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (wait_cnt == CEIL) |=> ((wait_cnt == CEIL) || (wait_cnt == '0)));

  p_last_busy_r5: assert property (@(posedge clk) disable iff (rst)
    last_phase |-> busy);

  p_claim_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (claimed && busy) |=> (claimed || addr_phase || !busy));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(xfer || wait_st || last_phase || stop_req || claimed));

  p_reset_gate_r9: assert property (@(posedge clk)
    rst |=> (!gnt_ok && !req_oe && req_n && !busy));

endmodule

bind busphase_tracker bpt_checker #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst(rst),
  .addr_phase(addr_phase), .xfer(xfer), .wait_st(wait_st),
  .last_phase(last_phase), .stop_req(stop_req), .claimed(claimed),
  .busy(busy), .wait_cnt(wait_cnt),
  .gnt_ok(gnt_ok), .req_n(req_n), .req_oe(req_oe)
);

// File: tb/busphase_tracker_tb.sv
`timescale 1ns/1ps
module busphase_tracker_tb;

  localparam int AD_W = 32;
  localparam int CBE_W = 4;
  localparam int WAIT_W = 4;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;
  logic [AD_W-1:0] ad = '0;
  logic [CBE_W-1:0] cbe_n = '0;
  logic gnt_n = 1'b1, req_want = 1'b0;
  logic addr_phase, xfer, wait_st, last_phase, stop_req, claimed, busy;
  logic [WAIT_W-1:0] wait_cnt;
  logic [AD_W-1:0] addr;
  logic [CBE_W-1:0] cmd;
  logic gnt_ok, req_n, req_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  busphase_tracker #(.AD_W(AD_W), .CBE_W(CBE_W), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .stop_n(stop_n), .ad(ad), .cbe_n(cbe_n),
    .gnt_n(gnt_n), .req_want(req_want),
    .addr_phase(addr_phase), .xfer(xfer), .wait_st(wait_st),
    .last_phase(last_phase), .stop_req(stop_req), .claimed(claimed),
    .busy(busy), .wait_cnt(wait_cnt), .addr(addr), .cmd(cmd),
    .gnt_ok(gnt_ok), .req_n(req_n), .req_oe(req_oe)
  );

  // {frame,irdy,trdy,devsel,stop asserted}, {ap,xf,ws,lp,sr,cl,bz}, wait_cnt
  localparam logic [15:0] VEC [NV] = '{
    {5'b00000, 7'b0000000, 4'd0},
    {5'b10000, 7'b1000001, 4'd0},
    {5'b11010, 7'b0010011, 4'd1},
    {5'b11110, 7'b0100011, 4'd0},
    {5'b11010, 7'b0010011, 4'd1},
    {5'b01010, 7'b0011011, 4'd2},
    {5'b01110, 7'b0101011, 4'd0},
    {5'b00000, 7'b0000000, 4'd0},
    {5'b00000, 7'b0000000, 4'd0},
    {5'b10000, 7'b1000001, 4'd0},
    {5'b11011, 7'b0000111, 4'd0},
    {5'b01011, 7'b0001111, 4'd0},
    {5'b00000, 7'b0000000, 4'd0},
    {5'b10000, 7'b1000001, 4'd0},
    {5'b11000, 7'b0010001, 4'd1},
    {5'b01000, 7'b0011001, 4'd2},
    {5'b00000, 7'b0000000, 4'd0},
    {5'b10000, 7'b1000001, 4'd0},
    {5'b01110, 7'b0101011, 4'd0},
    {5'b10000, 7'b1000001, 4'd0},
    {5'b01110, 7'b0101011, 4'd0},
    {5'b00000, 7'b0000000, 4'd0},
    {5'b00000, 7'b0000000, 4'd0}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [4:0] s);
    frame_n  = ~s[4];
    irdy_n   = ~s[3];
    trdy_n   = ~s[2];
    devsel_n = ~s[1];
    stop_n   = ~s[0];
  endtask

  // one bus clock: at the falling edge, present new values
  task automatic cyc(input logic [4:0] s);
    @(negedge clk);
    put(s);
  endtask

  task automatic check_vec(input int k);
    logic [15:0] v;
    v = VEC[k];
    chk("R1", $sformatf("addr_phase v%0d", k), 32'(addr_phase), 32'(v[10]));
    chk("R2", $sformatf("xfer v%0d", k), 32'(xfer), 32'(v[9]));
    chk("R3", $sformatf("wait_st v%0d", k), 32'(wait_st), 32'(v[8]));
    chk("R5", $sformatf("last_phase v%0d", k), 32'(last_phase), 32'(v[7]));
    chk("R6", $sformatf("stop_req v%0d", k), 32'(stop_req), 32'(v[6]));
    chk("R7", $sformatf("claimed v%0d", k), 32'(claimed), 32'(v[5]));
    chk("R8", $sformatf("busy v%0d", k), 32'(busy), 32'(v[4]));
    chk("R4", $sformatf("wait_cnt v%0d", k), 32'(wait_cnt), 32'(v[3:0]));
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs quiet and ignores the grant
    rst = 1'b1; gnt_n = 1'b0; req_want = 1'b1; put(5'b10000);
    repeat (3) @(negedge clk);
    chk("R9", "gnt_ok in reset", 32'(gnt_ok), 32'd0);
    chk("R9", "req_oe in reset", 32'(req_oe), 32'd0);
    chk("R9", "req_n in reset", 32'(req_n), 32'd1);
    chk("R9", "busy in reset", 32'(busy), 32'd0);
    chk("R9", "addr_phase in reset", 32'(addr_phase), 32'd0);
    put(5'b00000);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "req_oe first edge", 32'(req_oe), 32'd1);
    @(negedge clk);
    chk("R10", "gnt_ok follows grant", 32'(gnt_ok), 32'd1);
    chk("R10", "req_n follows want", 32'(req_n), 32'd0);
    req_want = 1'b0; gnt_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "req_n released", 32'(req_n), 32'd1);
    chk("R10", "gnt_ok released", 32'(gnt_ok), 32'd0);

    // table walk; R11: each vector checked two edges after it is presented
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check_vec(k - 2);
      if (k < NV) begin
        put(VEC[k][15:11]);
        ad    = 32'hC0DE_0000 | 32'(k);
        cbe_n = 4'(k);
      end else begin
        put(5'b00000);
      end
    end
    chk("R1", "addr from last table address clock", addr, 32'hC0DE_0013);
    chk("R1", "cmd from last table address clock", 32'(cmd), 32'h3);

    // R1: latch and hold during data clocks
    cyc(5'b00000);
    cyc(5'b10000); ad = 32'h1234_5678; cbe_n = 4'h7;
    cyc(5'b11010); ad = 32'hDEAD_BEEF; cbe_n = 4'h1;
    cyc(5'b11010);
    chk("R1", "addr latched", addr, 32'h1234_5678);
    chk("R1", "cmd latched", 32'(cmd), 32'h7);
    cyc(5'b01110);
    cyc(5'b00000);
    cyc(5'b00000);
    chk("R1", "addr held in data", addr, 32'h1234_5678);
    chk("R1", "cmd held in data", 32'(cmd), 32'h7);

    // R4: long stall saturates, transfer clears
    cyc(5'b10000);
    for (int w = 0; w < 20; w++) cyc(5'b11010);
    cyc(5'b01110);
    chk("R4", "saturated count", 32'(wait_cnt), 32'hF);
    chk("R3", "still waiting", 32'(wait_st), 32'd1);
    cyc(5'b00000);
    chk("R4", "held at ceiling", 32'(wait_cnt), 32'hF);
    cyc(5'b00000);
    chk("R4", "cleared at transfer", 32'(wait_cnt), 32'd0);
    chk("R2", "final transfer pulse", 32'(xfer), 32'd1);
    chk("R5", "final flagged", 32'(last_phase), 32'd1);
    cyc(5'b00000);
    chk("R8", "idle after final", 32'(busy), 32'd0);

    // R9: reset in mid-transaction
    cyc(5'b10000);
    cyc(5'b11010);
    cyc(5'b11010);
    cyc(5'b11010);
    chk("R8", "busy before reset", 32'(busy), 32'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R9", "busy cleared by reset", 32'(busy), 32'd0);
    chk("R9", "wait cleared by reset", 32'(wait_st), 32'd0);
    chk("R9", "req_oe off in reset", 32'(req_oe), 32'd0);
    put(5'b00000);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "idle after reset release", 32'(busy), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule